// File: doc/BRIEF.md
# Flash Sector Erase Sequencer with Pause and Resume

This block is the control-register front end and phase sequencer for erasing sectors of an embedded flash array. A host writes a small configuration word. The word holds a high-voltage enable bit, an erase bit, a program bit and a pause (suspend) bit. A read-only completion bit reports when a step has finished. A start write latches the sector selection mask and launches an erase. A simple countdown stands in for the erase pulse. The pulse is split into equal segments that act as checkpoints.

The host may pause an erase partway through. After a fixed settling latency the block reports completion and serves array reads. Reads that hit a sector selected for erase are flagged as poisoned, and their data is forced to zero. A later resume write continues the erase from the start of the segment that was interrupted, so the total erase time can grow. Reads issued while an erase is running or settling into the pause are rejected with a busy error.

The sequencer has four states. IDLE goes to RUN on *start*. RUN goes to SUSPENDING on *pause* and back to IDLE on *finish*. SUSPENDING goes to HALTED on *settle*. HALTED goes to RUN on *resume*.

Top module: `flash_ers_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0 and no read response flag is set.
- R2: In IDLE, a write with bit 0 (high-voltage enable) = 1, bit 2 (erase) = 1, bit 3 (program) = 0 and bit 1 (pause) = 0 starts an erase. Bit 10 (done) reads 0 from the next cycle. It rises exactly NSEG*SEG_LEN cycles after the start write, and stays low while the erase runs.
- R3: The pause bit is set only by a write during RUN whose bits 0, 1 and 2 are 1 and whose bit 3 is 0. Any other write, such as 0xF or 0x6, leaves the pause bit at 0.
- R4: After an accepted pause write, the pause bit reads 1 and done reads 0. Done rises exactly SUSP_LAT cycles after that write.
- R5: In HALTED, a write with bit 1 = 0 resumes the erase only if the enable bit already reads 1. Resuming clears the pause and done bits. If the enable bit reads 0, such a write is ignored. A write with bit 1 = 1 updates only the enable bit.
- R6: A resumed erase restarts at the beginning of the interrupted segment. Done rises NSEG*SEG_LEN - k*SEG_LEN cycles after the resume write, where k is the index of the interrupted segment.
- R7: In HALTED, a read of a sector whose bit was set in the mask latched at start returns `rd_poison` = 1 and zero data. A read of any other sector returns the array data unflagged.
- R8: A read issued in RUN or SUSPENDING returns `rd_busy_err` = 1 and zero data, with no poison flag.
- R9: A read issued in IDLE returns the array data with no flag. Every read response, including one under R7 or R8, appears one cycle after the request, with `rd_ack` = 1.
- R10: Writes in SUSPENDING are ignored. Writes in RUN other than a valid pause are ignored.
- R11: A pause write that lands on the final erase cycle wins over completion. Done stays low, and after resume the last segment runs again, taking SEG_LEN cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Write data: bit0 enable, bit1 pause, bit2 erase, bit3 program |
| cfg_rdata | output | 11 | Register read value; bit 10 is done |
| erase_sel | input | NSECT | Sector selection mask, latched on start |
| rd_req | input | 1 | Array read request |
| rd_sector | input | SECW | Sector addressed by the read |
| arr_rdata | input | DW | Data from the array for the read |
| rd_ack | output | 1 | Read response valid |
| rd_data | output | DW | Read response data |
| rd_poison | output | 1 | Read hit a sector under erase while halted |
| rd_busy_err | output | 1 | Read rejected because the erase is active |

## Verification
The pause request and the natural end of the erase can fall on the same clock edge. The bench provokes this by waiting until the erase counter sits on its final cycle and issuing the pause write on exactly that edge. It then judges the outcome in three ways: done must stay low, the pause bit must read 1, and the resumed erase must take one segment's length. A second overlap is a read or register write arriving while the block settles into the pause. There the bench expects a busy error and an unchanged register. A behavioural model compares every output on every cycle.

// File: rtl/flash_ers_pkg.sv
package flash_ers_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_RUN        = 2'd1,
        ST_SUSPENDING = 2'd2,
        ST_HALTED     = 2'd3
    } ers_state_e;

    localparam int BIT_HV    = 0;
    localparam int BIT_PAUSE = 1;
    localparam int BIT_ERASE = 2;
    localparam int BIT_PROG  = 3;
    localparam int BIT_DONE  = 10;
    localparam int WR_W      = BIT_PROG + 1;
    localparam int RD_W      = BIT_DONE + 1;

endpackage

// File: rtl/flash_ers_regs.sv
module flash_ers_regs
    import flash_ers_pkg::*;
#(
    parameter int NSECT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [WR_W-1:0]  cfg_wdata,
    input  logic [NSECT-1:0] erase_sel,
    input  ers_state_e       state,
    input  logic             fin,
    input  logic             pause_done,
    output logic             start_req,
    output logic             pause_req,
    output logic             resume_req,
    output logic [RD_W-1:0]  cfg_rdata,
    output logic [NSECT-1:0] mask
);

    logic hv_q, pa_q, er_q, pg_q, done_q;
    logic w_hv, w_pa, w_er, w_pg;

    always_comb begin
        w_hv = cfg_wdata[BIT_HV];
        w_pa = cfg_wdata[BIT_PAUSE];
        w_er = cfg_wdata[BIT_ERASE];
        w_pg = cfg_wdata[BIT_PROG];
        start_req  = cfg_we && (state == ST_IDLE) && w_hv && w_er && !w_pg && !w_pa;
        pause_req  = cfg_we && (state == ST_RUN) && w_hv && w_er && !w_pg && w_pa;
        resume_req = cfg_we && (state == ST_HALTED) && !w_pa && hv_q;
        cfg_rdata  = '0;
        cfg_rdata[BIT_HV]    = hv_q;
        cfg_rdata[BIT_PAUSE] = pa_q;
        cfg_rdata[BIT_ERASE] = er_q;
        cfg_rdata[BIT_PROG]  = pg_q;
        cfg_rdata[BIT_DONE]  = done_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hv_q   <= 1'b0;
            pa_q   <= 1'b0;
            er_q   <= 1'b0;
            pg_q   <= 1'b0;
            done_q <= 1'b0;
            mask   <= '0;
        end else begin
            if (cfg_we && state == ST_IDLE) begin
                hv_q <= w_hv;
                er_q <= w_er;
                pg_q <= w_pg;
            end
            if (start_req) begin
                done_q <= 1'b0;
                mask   <= erase_sel;
            end
            if (pause_req) begin
                pa_q   <= 1'b1;
                done_q <= 1'b0;
            end
            if (cfg_we && state == ST_HALTED) begin
                if (w_pa) begin
                    hv_q <= w_hv;
                end else if (hv_q) begin
                    hv_q   <= w_hv;
                    pa_q   <= 1'b0;
                    done_q <= 1'b0;
                end
            end
            if (fin || pause_done) done_q <= 1'b1;
        end
    end

    // R3
    pause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pa_q) |-> ($past(state) == ST_RUN));

    // R5
    resume_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pa_q) |-> ($past(state) == ST_HALTED && $past(hv_q)));

    // R2
    start_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> !done_q);

endmodule

// File: rtl/flash_ers_seq.sv
module flash_ers_seq
    import flash_ers_pkg::*;
#(
    parameter int SEG_LEN  = 6,
    parameter int NSEG     = 4,
    parameter int SUSP_LAT = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       pause_req,
    input  logic       resume_req,
    output ers_state_e state,
    output logic       fin,
    output logic       pause_done
);

    localparam int PW  = (SEG_LEN  > 1) ? $clog2(SEG_LEN)  : 1;
    localparam int SGW = (NSEG     > 1) ? $clog2(NSEG)     : 1;
    localparam int LW  = (SUSP_LAT > 1) ? $clog2(SUSP_LAT) : 1;

    ers_state_e     nxt;
    logic [PW-1:0]  pos;
    logic [SGW-1:0] seg;
    logic [LW-1:0]  lat;
    logic           last_step;

    assign last_step = (seg == SGW'(NSEG - 1)) && (pos == PW'(SEG_LEN - 1));

    always_comb begin
        nxt        = state;
        fin        = 1'b0;
        pause_done = 1'b0;
        unique case (state)
            ST_IDLE:       if (start_req) nxt = ST_RUN;
            ST_RUN: begin
                if (pause_req) nxt = ST_SUSPENDING;
                else if (last_step) begin
                    nxt = ST_IDLE;
                    fin = 1'b1;
                end
            end
            ST_SUSPENDING: if (lat == LW'(SUSP_LAT - 1)) begin
                nxt        = ST_HALTED;
                pause_done = 1'b1;
            end
            ST_HALTED:     if (resume_req) nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pos   <= '0;
            seg   <= '0;
            lat   <= '0;
        end else begin
            state <= nxt;
            if (start_req) begin
                pos <= '0;
                seg <= '0;
            end else if (resume_req) begin
                pos <= '0;
            end else if (state == ST_RUN && !pause_req && !last_step) begin
                if (pos == PW'(SEG_LEN - 1)) begin
                    pos <= '0;
                    seg <= seg + 1'b1;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
            if (pause_req) lat <= '0;
            else if (state == ST_SUSPENDING) lat <= lat + 1'b1;
        end
    end

    int lat_watch;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_watch <= 0;
        else if (state == ST_SUSPENDING) lat_watch <= lat_watch + 1;
        else lat_watch <= 0;
    end

    // R4
    susp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSPENDING) |-> (lat_watch < SUSP_LAT));

    // R6
    resume_ckpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |=> (pos == '0 && $stable(seg) && state == ST_RUN));

    // R11
    last_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && pause_req) |=> (state == ST_SUSPENDING));

endmodule

// File: rtl/flash_ers_rdgate.sv
module flash_ers_rdgate #(
    parameter int NSECT = 8,
    parameter int DW    = 32,
    parameter int SECW  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [SECW-1:0]  rd_sector,
    input  logic [DW-1:0]    arr_rdata,
    input  logic             busy,
    input  logic             halted,
    input  logic [NSECT-1:0] mask,
    output logic             rd_ack,
    output logic [DW-1:0]    rd_data,
    output logic             rd_poison,
    output logic             rd_busy_err
);

    logic hit;
    assign hit = halted && mask[rd_sector];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ack      <= 1'b0;
            rd_data     <= '0;
            rd_poison   <= 1'b0;
            rd_busy_err <= 1'b0;
        end else begin
            rd_ack      <= rd_req;
            rd_busy_err <= rd_req && busy;
            rd_poison   <= rd_req && hit;
            rd_data     <= (rd_req && !busy && !hit) ? arr_rdata : '0;
        end
    end

    // R8
    rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && busy) |=> (rd_busy_err && !rd_poison && rd_data == '0));

    // R7
    rd_poison_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_poison |-> ($past(halted) && rd_data == '0));

endmodule

// File: rtl/flash_ers_ctrl.sv
module flash_ers_ctrl
    import flash_ers_pkg::*;
#(
    parameter int NSECT    = 8,
    parameter int DW       = 32,
    parameter int SEG_LEN  = 6,
    parameter int NSEG     = 4,
    parameter int SUSP_LAT = 5,
    localparam int SECW    = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [WR_W-1:0]  cfg_wdata,
    output logic [RD_W-1:0]  cfg_rdata,
    input  logic [NSECT-1:0] erase_sel,
    input  logic             rd_req,
    input  logic [SECW-1:0]  rd_sector,
    input  logic [DW-1:0]    arr_rdata,
    output logic             rd_ack,
    output logic [DW-1:0]    rd_data,
    output logic             rd_poison,
    output logic             rd_busy_err
);

    ers_state_e       state;
    logic             start_req, pause_req, resume_req, fin, pause_done;
    logic [NSECT-1:0] mask;
    logic             busy, halted;

    assign busy   = (state == ST_RUN) || (state == ST_SUSPENDING);
    assign halted = (state == ST_HALTED);

    flash_ers_regs #(.NSECT(NSECT)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .erase_sel(erase_sel), .state(state), .fin(fin), .pause_done(pause_done),
        .start_req(start_req), .pause_req(pause_req), .resume_req(resume_req),
        .cfg_rdata(cfg_rdata), .mask(mask)
    );

    flash_ers_seq #(.SEG_LEN(SEG_LEN), .NSEG(NSEG), .SUSP_LAT(SUSP_LAT)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .pause_req(pause_req),
        .resume_req(resume_req), .state(state), .fin(fin), .pause_done(pause_done)
    );

    flash_ers_rdgate #(.NSECT(NSECT), .DW(DW), .SECW(SECW)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_sector(rd_sector),
        .arr_rdata(arr_rdata), .busy(busy), .halted(halted), .mask(mask),
        .rd_ack(rd_ack), .rd_data(rd_data), .rd_poison(rd_poison),
        .rd_busy_err(rd_busy_err)
    );

    // R2
    busy_done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cfg_rdata[BIT_DONE]);

endmodule

// File: tb/tb_flash_ers_ctrl.sv
`timescale 1ns/1ps
module tb_flash_ers_ctrl;

    localparam int NSECT = 8, DW = 32, SEG = 6, NSEG = 4, LAT = 5;
    localparam int TOTAL = SEG * NSEG;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [3:0]       cfg_wdata = '0;
    logic [10:0]      cfg_rdata;
    logic [NSECT-1:0] erase_sel = 8'h0C;
    logic             rd_req = 1'b0;
    logic [2:0]       rd_sector = '0;
    logic [DW-1:0]    arr_rdata = '0;
    logic             rd_ack, rd_poison, rd_busy_err;
    logic [DW-1:0]    rd_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_ers_ctrl #(.NSECT(NSECT), .DW(DW), .SEG_LEN(SEG), .NSEG(NSEG), .SUSP_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .erase_sel(erase_sel), .rd_req(rd_req),
        .rd_sector(rd_sector), .arr_rdata(arr_rdata), .rd_ack(rd_ack),
        .rd_data(rd_data), .rd_poison(rd_poison), .rd_busy_err(rd_busy_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model: 0 idle, 1 run, 2 settling, 3 halted
    int ms, m_cnt, m_lat;
    bit m_hv, m_pa, m_er, m_pg, m_done, m_ack, m_poi, m_bsy, m_busy, m_hit;
    logic [NSECT-1:0] m_mask;
    logic [DW-1:0]    m_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; m_cnt = 0; m_lat = 0;
            {m_hv, m_pa, m_er, m_pg, m_done, m_ack, m_poi, m_bsy} = '0;
            m_mask = '0; m_data = '0;
        end else begin
            m_busy = (ms == 1 || ms == 2);
            m_hit  = (ms == 3) && m_mask[rd_sector];
            m_ack  = rd_req;
            m_bsy  = rd_req && m_busy;
            m_poi  = rd_req && m_hit;
            m_data = (rd_req && !m_busy && !m_hit) ? arr_rdata : '0;
            case (ms)
                0: if (cfg_we) begin
                    m_hv = cfg_wdata[0]; m_er = cfg_wdata[2]; m_pg = cfg_wdata[3];
                    if (cfg_wdata == 4'h5) begin
                        ms = 1; m_cnt = 0; m_done = 0; m_mask = erase_sel;
                    end
                end
                1: if (cfg_we && cfg_wdata == 4'h7) begin
                    ms = 2; m_lat = 0; m_pa = 1; m_done = 0;
                end else if (m_cnt == TOTAL - 1) begin
                    ms = 0; m_done = 1;
                end else m_cnt++;
                2: if (m_lat == LAT - 1) begin
                    ms = 3; m_done = 1;
                end else m_lat++;
                default: if (cfg_we) begin
                    if (cfg_wdata[1]) m_hv = cfg_wdata[0];
                    else if (m_hv) begin
                        m_hv = cfg_wdata[0]; m_pa = 0; m_done = 0; ms = 1;
                        m_cnt = (m_cnt / SEG) * SEG;
                    end
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [10:0] er;
            er = '0;
            er[0] = m_hv; er[1] = m_pa; er[2] = m_er; er[3] = m_pg; er[10] = m_done;
            // R1 R2 R4 R6 R10 R11 register model
            chk(cfg_rdata == er, "R2 R4 R6 R10 R11 model reg", cfg_rdata, er);
            // R7 R8 R9 read model
            chk({rd_ack, rd_poison, rd_busy_err} == {m_ack, m_poi, m_bsy} && rd_data == m_data,
                "R7 R8 R9 model read", {rd_ack, rd_poison, rd_busy_err, rd_data},
                {m_ack, m_poi, m_bsy, m_data});
        end
    end

    task automatic wr(input logic [3:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] s, input logic [DW-1:0] d);
        rd_req = 1'b1; rd_sector = s; arr_rdata = d;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!cfg_rdata[10] && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk(cfg_rdata == 11'h0, "R1 reset reg", cfg_rdata, 0);
        chk(!rd_ack && !rd_poison && !rd_busy_err, "R1 reset read flags",
            {rd_ack, rd_poison, rd_busy_err}, 0);

        rd(3'd3, 32'hA5A5_0001);
        chk(rd_ack && rd_data == 32'hA5A5_0001 && !rd_poison && !rd_busy_err,
            "R9 idle read", rd_data, 32'hA5A5_0001);

        // plain erase
        wr(4'h5);
        chk(cfg_rdata == 11'h005, "R2 start reg", cfg_rdata, 11'h005);
        wait_done(n);
        chk(n == TOTAL, "R2 erase length", n, TOTAL);
        chk(cfg_rdata == 11'h405, "R2 finished reg", cfg_rdata, 11'h405);

        // erase with pause in segment 2
        wr(4'h5);
        wr(4'hF);
        chk(cfg_rdata[1] == 1'b0, "R3 pause with program bit", cfg_rdata, 11'h005);
        wr(4'h6);
        chk(cfg_rdata == 11'h005, "R3 pause without enable", cfg_rdata, 11'h005);
        rd(3'd2, 32'h1234);
        chk(rd_ack && rd_busy_err && !rd_poison && rd_data == 0, "R8 read while running",
            {rd_busy_err, rd_poison, rd_data}, {1'b1, 1'b0, 32'h0});
        wr(4'h0);
        chk(cfg_rdata == 11'h005, "R10 write in run ignored", cfg_rdata, 11'h005);
        idle(10);
        wr(4'h7);
        chk(cfg_rdata == 11'h007, "R4 pause accepted", cfg_rdata, 11'h007);
        wait_done(n);
        chk(n == LAT, "R4 pause latency", n, LAT);
        rd(3'd2, 32'hBEEF);
        chk(rd_poison && !rd_busy_err && rd_data == 0, "R7 poisoned sector",
            {rd_poison, rd_data}, {1'b1, 32'h0});
        rd(3'd5, 32'hCAFE);
        chk(!rd_poison && !rd_busy_err && rd_data == 32'hCAFE, "R7 clean sector",
            rd_data, 32'hCAFE);
        wr(4'h6);
        chk(cfg_rdata == 11'h406, "R5 enable cleared", cfg_rdata, 11'h406);
        wr(4'h4);
        chk(cfg_rdata == 11'h406, "R5 resume without enable ignored", cfg_rdata, 11'h406);
        rd(3'd3, 32'h77);
        chk(rd_poison, "R5 still halted", rd_poison, 1);
        wr(4'h7);
        chk(cfg_rdata == 11'h407, "R5 enable restored", cfg_rdata, 11'h407);
        wr(4'h5);
        chk(cfg_rdata == 11'h005, "R5 resume reg", cfg_rdata, 11'h005);
        wait_done(n);
        chk(n == TOTAL - 2 * SEG, "R6 checkpoint restart", n, TOTAL - 2 * SEG);

        // pause on final erase cycle
        wr(4'h5);
        idle(TOTAL - 1);
        wr(4'h7);
        chk(cfg_rdata == 11'h007, "R11 pause beats finish", cfg_rdata, 11'h007);
        wr(4'h0);
        chk(cfg_rdata == 11'h007, "R10 write while settling ignored", cfg_rdata, 11'h007);
        rd(3'd1, 32'h55);
        chk(rd_busy_err && rd_data == 0, "R8 read while settling", rd_busy_err, 1);
        wait_done(n);
        wr(4'h5);
        wait_done(n);
        chk(n == SEG, "R11 last segment rerun", n, SEG);

        idle(2);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            chk(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule